// File: doc/BRIEF.md
# Double-Buffered 12-Bit DAC Write Port

This block sits on an 8-bit processor bus and assembles a 12-bit converter code from two byte writes, so that the parallel code presented to the converter never shows a mix of old and new bits. A write to the "stage" page of a channel parks its part of the code in a holding register and leaves the output alone. A write to the "commit" page of that channel takes the rest of the code from the data bus and updates all twelve output bits together. The software splits a value in the range 0 to 4095 into an upper byte (value / 16) and a lower nibble (value mod 16).

Decoding is partial. An external active-low select means "address top nibble is 9". Only the low nibble of the address high byte picks the page, and the low address byte never reaches the block. A strobe is accepted only on a write, while the bus clock-phase qualifier is high. Every strobe is edge-detected against the system clock, so a strobe held for several cycles loads once. Channel k uses pages 2k (upper byte) and 2k+1 (lower nibble). With the default arrangement the upper byte is staged and the lower-nibble write commits. The alternative arrangement stages the lower nibble instead, so that one upper-page write commits. That mode also allows plain 8-bit use.

Top module: `dac_port_top`

## Requirements
- R1: After reset every channel's 12-bit output and every staging register read zero, so a first commit write produces a code whose staged part is 0.
- R2: In the default mode (STAGE_LOW=0), a write to page 2k stores data bits 7..0 as the pending upper byte of channel k, and channel k's output does not change.
- R3: In the default mode, a write to page 2k+1 sets channel k's output to {pending upper byte, data bits 3..0} in one clock cycle. Data bits 7..4 are ignored. The output changes one rising clock edge after the accepted strobe.
- R4: Only address-high bits 3..0 are compared against the page number. Address-high bits 7..4 have no effect, because the external select stands for them.
- R5: No write is accepted while the phase qualifier is low or the active-low select is high.
- R6: A read cycle (busRnW=1) to any page changes neither the output nor the pending register.
- R7: A strobe held active for several cycles loads exactly once, with the data present in its first cycle.
- R8: Two stage writes with no commit between them leave the second byte pending, and the output keeps its earlier value.
- R9: Channel k (k < NUM_CH) responds only to pages 2k and 2k+1, and the channels are independent. Pages at or above 2*NUM_CH are ignored.
- R10: With STAGE_LOW=1, a write to page 2k+1 stores data bits 3..0 as the pending low nibble with no output change. A write to page 2k sets the output to {data bits 7..0, pending nibble}, and the nibble stays pending for further upper-page writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrHi | input | 8 | Address bits 15..8 of the bus |
| dataIn | input | 8 | Bus data byte |
| busRnW | input | 1 | 1 = read cycle, 0 = write cycle |
| phaseQual | input | 1 | Bus clock-phase qualifier, active high |
| pageSelN | input | 1 | Active-low select for address top nibble 9 |
| dacCode | output | 12*NUM_CH | Channel k code in bits 12k+11..12k |

## Verification
The main function is tried with a fresh stage-then-commit pair, with two stage writes before one commit, and with a commit straight after reset. Between them these separate a correct pending byte from a stale or reset value. Commit data with its high nibble set shows that only bits 3..0 land. Address bytes with arbitrary top nibbles show that the decode is partial. Reads, a low phase qualifier and a deasserted select are each followed by a real commit, which exposes any hidden change to the pending byte. A strobe held across a change of data tells single-shot edge detection apart from level loading. A second instance in the low-nibble-staged mode confirms that the roles of the two pages swap.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;
  localparam int CODE_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = CODE_W - BYTE_W;

  // per-channel load strobes from control to datapath
  typedef struct packed {
    logic stageLd;   // load the pending register
    logic commitLd;  // load the output register
  } chStrobe_t;
endpackage

// File: rtl/dac_port_ctrl.sv
module dac_port_ctrl
  import dac_port_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int STAGE_LOW = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [3:0]             pageNib,
  input  logic                   busRnW,
  input  logic                   phaseQual,
  input  logic                   pageSelN,
  output chStrobe_t [NUM_CH-1:0] strobes
);
  // two pages per channel; must fit the 16 pages of one select
  localparam int NUM_PAGES = 2 * NUM_CH;

  logic [NUM_PAGES-1:0] pageHit;
  logic [NUM_PAGES-1:0] pageHitQ;
  logic [NUM_PAGES-1:0] pageRise;

  always_comb begin
    for (int p = 0; p < NUM_PAGES; p++) begin
      pageHit[p] = phaseQual && !pageSelN && !busRnW && (pageNib == 4'(p));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pageHitQ <= '0;
    else       pageHitQ <= pageHit;
  end

  assign pageRise = pageHit & ~pageHitQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (STAGE_LOW == 0) begin : g_stageHi
      assign strobes[c].stageLd  = pageRise[2*c];
      assign strobes[c].commitLd = pageRise[2*c+1];
    end else begin : g_stageLo
      assign strobes[c].stageLd  = pageRise[2*c+1];
      assign strobes[c].commitLd = pageRise[2*c];
    end
  end
endmodule

// File: rtl/dac_port_dpath.sv
module dac_port_dpath
  import dac_port_pkg::*;
#(
  parameter int STAGE_LOW = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] dataIn,
  input  chStrobe_t         strobe,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] codeQ;

  if (STAGE_LOW == 0) begin : g_stageHi
    logic [BYTE_W-1:0] pendHi;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendHi <= '0;
        codeQ  <= '0;
      end else begin
        if (strobe.stageLd)  pendHi <= dataIn;
        if (strobe.commitLd) codeQ  <= {pendHi, dataIn[NIB_W-1:0]};
      end
    end
  end else begin : g_stageLo
    logic [NIB_W-1:0] pendLo;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendLo <= '0;
        codeQ  <= '0;
      end else begin
        if (strobe.stageLd)  pendLo <= dataIn[NIB_W-1:0];
        if (strobe.commitLd) codeQ  <= {dataIn, pendLo};
      end
    end
  end

  assign code = codeQ;
endmodule

// File: rtl/dac_port_top.sv
module dac_port_top
  import dac_port_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int STAGE_LOW = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               addrHi,
  input  logic [7:0]               dataIn,
  input  logic                     busRnW,
  input  logic                     phaseQual,
  input  logic                     pageSelN,
  output logic [NUM_CH*CODE_W-1:0] dacCode
);
  chStrobe_t [NUM_CH-1:0] strobes;

  dac_port_ctrl #(.NUM_CH(NUM_CH), .STAGE_LOW(STAGE_LOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageNib(addrHi[3:0]), .busRnW(busRnW),
    .phaseQual(phaseQual), .pageSelN(pageSelN), .strobes(strobes)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dp
    dac_port_dpath #(.STAGE_LOW(STAGE_LOW)) u_dpath (
      .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobes[c]),
      .code(dacCode[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_port_chk.sv
module dac_port_chk
  import dac_port_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busRnW,
  input logic                     phaseQual,
  input chStrobe_t [NUM_CH-1:0]   strobes,
  input logic [NUM_CH*CODE_W-1:0] dacCode
);
  logic [NUM_CH-1:0] commitVec;
  logic [NUM_CH-1:0] stageVec;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      commitVec[c] = strobes[c].commitLd;
      stageVec[c]  = strobes[c].stageLd;
    end
  end

  // R6
  read_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRnW |=> $stable(dacCode));

  // R5
  phase_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phaseQual |-> (commitVec == '0 && stageVec == '0));

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stageVec) |=> $stable(dacCode));

  // R9
  onehot_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitVec, stageVec}));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R7
    single_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
      commitVec[c] |=> !commitVec[c]);
  end
endmodule

bind dac_port_top dac_port_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .busRnW(busRnW), .phaseQual(phaseQual),
  .strobes(strobes), .dacCode(dacCode)
);

// File: tb/sim_dac_port_top.sv
module sim_dac_port_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addrHi = 8'h00;
  logic [7:0] dataIn = 8'h00;
  logic busRnW = 1'b1;
  logic phaseQual = 1'b0;
  logic selN0 = 1'b1;
  logic selN1 = 1'b1;
  logic [23:0] code0;
  logic [11:0] code1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_port_top #(.NUM_CH(2), .STAGE_LOW(0)) u0 (
    .clk(clk), .rstN(rstN), .addrHi(addrHi), .dataIn(dataIn), .busRnW(busRnW),
    .phaseQual(phaseQual), .pageSelN(selN0), .dacCode(code0)
  );

  dac_port_top #(.NUM_CH(1), .STAGE_LOW(1)) u1 (
    .clk(clk), .rstN(rstN), .addrHi(addrHi), .dataIn(dataIn), .busRnW(busRnW),
    .phaseQual(phaseQual), .pageSelN(selN1), .dacCode(code1)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle on either instance, then one idle cycle
  task automatic busCycle(input bit toU1, input logic [7:0] addr, input logic [7:0] data,
                          input logic rnw, input logic phase, input logic sel);
    addrHi = addr; dataIn = data; busRnW = rnw; phaseQual = phase;
    selN0 = toU1 ? 1'b1 : sel;
    selN1 = toU1 ? sel : 1'b1;
    @(negedge clk);
    phaseQual = 1'b0; selN0 = 1'b1; selN1 = 1'b1; busRnW = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr0(input logic [7:0] addr, input logic [7:0] data);
    busCycle(1'b0, addr, data, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testReset();
    check("R1 reset code u0", code0, 24'h0);
    check("R1 reset code u1", {12'h0, code1}, 24'h0);
    wr0(8'h91, 8'h06);
    check("R1 pending byte zero after reset", code0[11:0], 12'h006);
  endtask

  task automatic testStageCommit();
    wr0(8'h90, 8'hAB);
    check("R2 stage write leaves output", code0[11:0], 12'h006);
    wr0(8'h91, 8'hFC);
    check("R3 commit 2748 = AB/C", code0[11:0], 12'hABC);
  endtask

  task automatic testOverwrite();
    wr0(8'h90, 8'h11);
    wr0(8'h90, 8'h22);
    check("R8 output held across two stage writes", code0[11:0], 12'hABC);
    wr0(8'h91, 8'h03);
    check("R8 second staged byte wins", code0[11:0], 12'h223);
  endtask

  task automatic testPartial();
    wr0(8'h50, 8'h44);
    wr0(8'hE1, 8'h05);
    check("R4 top nibble of address ignored", code0[11:0], 12'h445);
  endtask

  task automatic testQualify();
    busCycle(1'b0, 8'h91, 8'h09, 1'b0, 1'b0, 1'b0);
    check("R5 phase low ignored", code0[11:0], 12'h445);
    busCycle(1'b0, 8'h91, 8'h09, 1'b0, 1'b1, 1'b1);
    check("R5 select high ignored", code0[11:0], 12'h445);
    busCycle(1'b0, 8'h90, 8'h77, 1'b0, 1'b0, 1'b0);
    wr0(8'h91, 8'h01);
    check("R5 unqualified stage ignored", code0[11:0], 12'h441);
  endtask

  task automatic testRead();
    busCycle(1'b0, 8'h90, 8'h99, 1'b1, 1'b1, 1'b0);
    busCycle(1'b0, 8'h91, 8'h0F, 1'b1, 1'b1, 1'b0);
    check("R6 read leaves output", code0[11:0], 12'h441);
    wr0(8'h91, 8'h06);
    check("R6 read leaves pending byte", code0[11:0], 12'h446);
  endtask

  task automatic testHeld();
    wr0(8'h90, 8'h77);
    addrHi = 8'h91; dataIn = 8'h08; busRnW = 1'b0; phaseQual = 1'b1; selN0 = 1'b0;
    @(negedge clk);
    check("R7 first cycle of held strobe loads", code0[11:0], 12'h778);
    dataIn = 8'h09;
    @(negedge clk);
    @(negedge clk);
    check("R7 held strobe does not reload", code0[11:0], 12'h778);
    phaseQual = 1'b0; selN0 = 1'b1; busRnW = 1'b1;
    @(negedge clk);
    check("R7 value after release", code0[11:0], 12'h778);
  endtask

  task automatic testChannels();
    wr0(8'h92, 8'h5A);
    wr0(8'h93, 8'h01);
    check("R9 channel 1 commit", code0[23:12], 12'h5A1);
    check("R9 channel 0 untouched", code0[11:0], 12'h778);
    wr0(8'h9F, 8'h33);
    wr0(8'h94, 8'h33);
    check("R9 unmapped pages ignored", code0, 24'h5A1778);
  endtask

  task automatic testStageLow();
    busCycle(1'b1, 8'h91, 8'hF5, 1'b0, 1'b1, 1'b0);
    check("R10 nibble stage leaves output", {12'h0, code1}, 24'h0);
    busCycle(1'b1, 8'h90, 8'hAB, 1'b0, 1'b1, 1'b0);
    check("R10 upper write commits", {12'h0, code1}, 24'hAB5);
    busCycle(1'b1, 8'h90, 8'h12, 1'b0, 1'b1, 1'b0);
    check("R10 nibble stays pending", {12'h0, code1}, 24'h125);
    check("R10 other instance untouched", code0, 24'h5A1778);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStageCommit();
    testOverwrite();
    testPartial();
    testQualify();
    testRead();
    testHeld();
    testChannels();
    testStageLow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule